// File: doc/BRIEF.md
# Prioritized Region Memory Protection Checker

This block sits on a processor's access path and decides, for each access, whether it may proceed. It holds a bank of programmable protection regions. Every region has a base, a power-of-two size, a two-bit permission field, a cacheable flag, a bufferable flag and an enable. An incoming address is compared against all enabled regions in parallel. Where several regions claim the same address, the one with the highest index wins. The block returns that region's cacheable and bufferable flags, and it raises an abort when the access breaks the region's permission or when no region claims the address.

No address translation takes place. The address handed onward is the incoming address, registered alongside the verdict. Software programs the regions through a single write port that carries a region index and every field of that region at once. A global enable input bypasses the whole check when it is low.

The response path is a two-state machine. In `ST_IDLE` no result is presented. In `ST_RESP` the registered result of the previous cycle's request is presented with `rsp_valid` high. The transition `IDLE->RESP` is taken whenever a request is sampled, and so is `RESP->RESP`. The transitions `RESP->IDLE` and `IDLE->IDLE` are taken on any cycle without a request.

Top module: `prot_region_checker`

## Requirements
- R1: Eight regions exist. A write with `cfg_we` high loads index `cfg_idx` with all of its fields on the clock edge. A request sampled on that same edge is still judged against the old settings.
- R2: Size code N (`cfg_size`) describes a region of 2^(N+1) bytes, and codes 11 (4 KB) through 31 (4 GB) are valid. The region covers the aligned block that contains `cfg_base`, so base bits below N+1 are ignored.
- R3: A region programmed with a size code below 11 never matches.
- R4: A region whose enable bit is 0 never matches, whatever its base and size.
- R5: When several enabled regions match an address, the region with the highest index supplies the permission, cacheable and bufferable values.
- R6: Permission codes work as follows: 2'b00 denies every access; 2'b01 allows only privileged accesses (read or write); 2'b10 allows privileged read/write and user reads; 2'b11 allows everything. An access is a write when `req_write` is 1 and privileged when `req_priv` is 1.
- R7: With the global enable high, an access that matches no region aborts.
- R8: With `glob_en` low, every access passes with abort, cacheable and bufferable all 0.
- R9: An aborted response always has cacheable and bufferable at 0. A passed response carries the winning region's flags.
- R10: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high. `rsp_addr` then equals the sampled `req_addr`.
- R11: After reset, `rsp_valid` is 0 and every region is disabled, so the first enabled access aborts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Region write strobe |
| cfg_idx | input | 3 | Region index written |
| cfg_base | input | 32 | Region base address |
| cfg_size | input | 5 | Size code N, region = 2^(N+1) bytes |
| cfg_perm | input | 2 | Permission code |
| cfg_cach | input | 1 | Cacheable flag |
| cfg_buf | input | 1 | Bufferable flag |
| cfg_en | input | 1 | Region enable |
| glob_en | input | 1 | Global protection enable |
| req_valid | input | 1 | Access request strobe |
| req_addr | input | 32 | Access address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_priv | input | 1 | 1 = privileged, 0 = user |
| rsp_valid | output | 1 | Result strobe, one cycle after request |
| rsp_addr | output | 32 | Untranslated address passed onward |
| rsp_cach | output | 1 | Cacheable attribute of the access |
| rsp_buf | output | 1 | Bufferable attribute of the access |
| rsp_abort | output | 1 | Access fault |

## Verification
The assertions check, on every cycle, the one-cycle response timing and the unchanged address, the clean pass-through when protection is globally off, and that an abort never carries cache attributes. Which region wins, how size codes mask the base, how permissions are decoded, and how disabled or under-sized regions are skipped all depend on the programmed region state. Only the bench's scenarios can show these. They run against a behavioural model that keeps its own copy of the region table and is compared on every clock.

// File: rtl/prc_pkg.sv
package prc_pkg;
    localparam int ADDR_W = 32;
    localparam int SIZE_W = 5;

    typedef enum logic [1:0] {
        PERM_NONE    = 2'b00,
        PERM_PRIV    = 2'b01,
        PERM_PRIV_UR = 2'b10,
        PERM_FULL    = 2'b11
    } perm_t;

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] base;
        logic [SIZE_W-1:0] size;
        perm_t             perm;
        logic              cach;
        logic              bufb;
    } region_cfg_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } rsp_state_t;
endpackage

// File: rtl/prc_region_file.sv
module prc_region_file
    import prc_pkg::*;
#(
    parameter int NUM_REGIONS = 8,
    localparam int IDX_W = $clog2(NUM_REGIONS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  region_cfg_t       wdata_i,
    output region_cfg_t       regs_o [NUM_REGIONS]
);
    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs_o[g] <= '0;
            end else if (we_i && (idx_i == IDX_W'(g))) begin
                regs_o[g] <= wdata_i;
            end
        end
    end
endmodule

// File: rtl/prc_region_match.sv
module prc_region_match
    import prc_pkg::*;
#(
    parameter int MIN_CODE = 11
) (
    input  region_cfg_t       cfg_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hit_o
);
    logic [ADDR_W-1:0] cmp_mask;
    logic              size_ok;

    always_comb begin
        for (int b = 0; b < ADDR_W; b++) begin
            cmp_mask[b] = (b > int'(cfg_i.size));
        end
    end

    assign size_ok = (int'(cfg_i.size) >= MIN_CODE);
    assign hit_o   = cfg_i.en && size_ok &&
                     (((addr_i ^ cfg_i.base) & cmp_mask) == '0);
endmodule

// File: rtl/prc_priority_sel.sv
module prc_priority_sel #(
    parameter int NUM_REGIONS = 8,
    localparam int IDX_W = $clog2(NUM_REGIONS)
) (
    input  logic [NUM_REGIONS-1:0] hit_i,
    output logic                   any_o,
    output logic [IDX_W-1:0]       idx_o
);
    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        for (int i = 0; i < NUM_REGIONS; i++) begin
            if (hit_i[i]) begin
                any_o = 1'b1;
                idx_o = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/prot_region_checker.sv
module prot_region_checker
    import prc_pkg::*;
#(
    parameter int NUM_REGIONS = 8,
    parameter int MIN_CODE    = 11,
    localparam int IDX_W = $clog2(NUM_REGIONS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [31:0]       cfg_base,
    input  logic [4:0]        cfg_size,
    input  logic [1:0]        cfg_perm,
    input  logic              cfg_cach,
    input  logic              cfg_buf,
    input  logic              cfg_en,
    input  logic              glob_en,
    input  logic              req_valid,
    input  logic [31:0]       req_addr,
    input  logic              req_write,
    input  logic              req_priv,
    output logic              rsp_valid,
    output logic [31:0]       rsp_addr,
    output logic              rsp_cach,
    output logic              rsp_buf,
    output logic              rsp_abort
);
    region_cfg_t             wdata;
    region_cfg_t             regs [NUM_REGIONS];
    logic [NUM_REGIONS-1:0]  hits;
    logic                    any_hit;
    logic [IDX_W-1:0]        win_idx;
    region_cfg_t             win;
    logic                    allowed;
    logic                    abort_d, cach_d, buf_d;
    rsp_state_t              state, state_nxt;

    always_comb begin
        wdata.en   = cfg_en;
        wdata.base = cfg_base;
        wdata.size = cfg_size;
        wdata.perm = perm_t'(cfg_perm);
        wdata.cach = cfg_cach;
        wdata.bufb = cfg_buf;
    end

    prc_region_file #(.NUM_REGIONS(NUM_REGIONS)) u_file (
        .clk(clk), .rst_n(rst_n), .we_i(cfg_we), .idx_i(cfg_idx),
        .wdata_i(wdata), .regs_o(regs)
    );

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_match
        prc_region_match #(.MIN_CODE(MIN_CODE)) u_match (
            .cfg_i(regs[g]), .addr_i(req_addr), .hit_o(hits[g])
        );
    end

    prc_priority_sel #(.NUM_REGIONS(NUM_REGIONS)) u_sel (
        .hit_i(hits), .any_o(any_hit), .idx_o(win_idx)
    );

    assign win = regs[win_idx];

    always_comb begin
        unique case (win.perm)
            PERM_NONE:    allowed = 1'b0;
            PERM_PRIV:    allowed = req_priv;
            PERM_PRIV_UR: allowed = req_priv || !req_write;
            PERM_FULL:    allowed = 1'b1;
            default:      allowed = 1'b0;
        endcase
    end

    always_comb begin
        if (!glob_en) begin
            abort_d = 1'b0;
            cach_d  = 1'b0;
            buf_d   = 1'b0;
        end else if (!any_hit || !allowed) begin
            abort_d = 1'b1;
            cach_d  = 1'b0;
            buf_d   = 1'b0;
        end else begin
            abort_d = 1'b0;
            cach_d  = win.cach;
            buf_d   = win.bufb;
        end
    end

    always_comb begin
        unique case (state)
            ST_IDLE: state_nxt = req_valid ? ST_RESP : ST_IDLE;
            ST_RESP: state_nxt = req_valid ? ST_RESP : ST_IDLE;
            default: state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_addr  <= '0;
            rsp_cach  <= 1'b0;
            rsp_buf   <= 1'b0;
            rsp_abort <= 1'b0;
        end else if (req_valid) begin
            rsp_addr  <= req_addr;
            rsp_cach  <= cach_d;
            rsp_buf   <= buf_d;
            rsp_abort <= abort_d;
        end
    end

    assign rsp_valid = (state == ST_RESP);
endmodule

// File: rtl/prc_checker.sv
module prc_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        glob_en,
    input logic        req_valid,
    input logic [31:0] req_addr,
    input logic        rsp_valid,
    input logic [31:0] rsp_addr,
    input logic        rsp_cach,
    input logic        rsp_buf,
    input logic        rsp_abort
);
    // R10
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    // R10
    rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    // R10
    addr_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (rsp_addr == $past(req_addr)));
    // R8
    glob_off_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !glob_en) |=> (!rsp_abort && !rsp_cach && !rsp_buf));
    // R9
    abort_no_attr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_abort) |-> (!rsp_cach && !rsp_buf));
endmodule

bind prot_region_checker prc_checker u_prc_checker (
    .clk(clk), .rst_n(rst_n), .glob_en(glob_en), .req_valid(req_valid),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_addr(rsp_addr),
    .rsp_cach(rsp_cach), .rsp_buf(rsp_buf), .rsp_abort(rsp_abort)
);

// File: tb/test_prot_region_checker.sv
module test_prot_region_checker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic [31:0] cfg_base = '0;
    logic [4:0]  cfg_size = '0;
    logic [1:0]  cfg_perm = '0;
    logic        cfg_cach = 1'b0, cfg_buf = 1'b0, cfg_en = 1'b0;
    logic        glob_en = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0, req_priv = 1'b0;
    logic        rsp_valid;
    logic [31:0] rsp_addr;
    logic        rsp_cach, rsp_buf, rsp_abort;

    int compared = 0;
    int mismatched = 0;

    bit          m_en [8];
    logic [31:0] m_base [8];
    int          m_size [8];
    int          m_perm [8];
    bit          m_c [8];
    bit          m_b [8];

    always #2.5 clk = ~clk;

    prot_region_checker i_prot_region_checker (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_base(cfg_base), .cfg_size(cfg_size), .cfg_perm(cfg_perm),
        .cfg_cach(cfg_cach), .cfg_buf(cfg_buf), .cfg_en(cfg_en),
        .glob_en(glob_en), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .req_priv(req_priv), .rsp_valid(rsp_valid),
        .rsp_addr(rsp_addr), .rsp_cach(rsp_cach), .rsp_buf(rsp_buf),
        .rsp_abort(rsp_abort)
    );

    function automatic void ref_eval(input logic [31:0] a, input bit w, input bit p,
                                     output bit ab, output bit c, output bit b);
        int best = -1;
        bit ok;
        for (int i = 0; i < 8; i++) begin
            if (m_en[i] && m_size[i] >= 11) begin
                longint unsigned sz = 64'd1 << (m_size[i] + 1);
                longint unsigned lo = {32'd0, m_base[i]} & ~(sz - 1);
                longint unsigned aa = {32'd0, a};
                if (aa >= lo && aa < lo + sz) best = i;
            end
        end
        ab = 0; c = 0; b = 0;
        if (!glob_en) return;
        if (best < 0) begin ab = 1; return; end
        case (m_perm[best])
            0: ok = 0;
            1: ok = p;
            2: ok = p || !w;
            default: ok = 1;
        endcase
        if (!ok) begin ab = 1; return; end
        c = m_c[best];
        b = m_b[best];
    endfunction

    task automatic cycle(input string tag);
        bit ev, eab, ec, eb;
        logic [31:0] ea;
        ev = req_valid;
        ea = req_addr;
        ref_eval(req_addr, req_write, req_priv, eab, ec, eb);
        @(posedge clk);
        if (cfg_we) begin
            m_en[cfg_idx]   = cfg_en;
            m_base[cfg_idx] = cfg_base;
            m_size[cfg_idx] = int'(cfg_size);
            m_perm[cfg_idx] = int'(cfg_perm);
            m_c[cfg_idx]    = cfg_cach;
            m_b[cfg_idx]    = cfg_buf;
        end
        @(negedge clk);
        compared++;
        if (rsp_valid !== ev) begin
            mismatched++;
            $display("FAIL %s rsp_valid actual=%0b expected=%0b", tag, rsp_valid, ev);
        end else if (ev && {rsp_abort, rsp_cach, rsp_buf, rsp_addr} !== {eab, ec, eb, ea}) begin
            mismatched++;
            $display("FAIL %s abort/c/b/addr actual=%0b%0b%0b/%h expected=%0b%0b%0b/%h",
                     tag, rsp_abort, rsp_cach, rsp_buf, rsp_addr, eab, ec, eb, ea);
        end
    endtask

    task automatic wr_region(input int idx, input logic [31:0] base, input int size,
                             input int perm, input bit c, input bit b, input bit en,
                             input string tag);
        cfg_we = 1; cfg_idx = 3'(idx); cfg_base = base; cfg_size = 5'(size);
        cfg_perm = 2'(perm); cfg_cach = c; cfg_buf = b; cfg_en = en;
        cycle(tag);
        cfg_we = 0;
    endtask

    task automatic access(input logic [31:0] a, input bit w, input bit p, input string tag);
        req_valid = 1; req_addr = a; req_write = w; req_priv = p;
        cycle(tag);
        req_valid = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) begin
            m_en[i] = 0; m_base[i] = '0; m_size[i] = 0; m_perm[i] = 0; m_c[i] = 0; m_b[i] = 0;
        end
        repeat (3) @(negedge clk);
        compared++;
        if (rsp_valid !== 1'b0) begin
            mismatched++;
            $display("FAIL R11 rsp_valid in reset actual=%0b expected=0", rsp_valid);
        end
        rst_n = 1;
        @(negedge clk);
        // R11: fresh regions all disabled -> abort (R7)
        cycle("R11");
        access(32'h0000_0100, 0, 1, "R11");
        access(32'hFFFF_F000, 1, 1, "R7");

        // R2: smallest region 4 KB at 0
        wr_region(0, 32'h0000_0000, 11, 3, 1, 0, 1, "R2");
        access(32'h0000_0FFF, 1, 0, "R2");
        access(32'h0000_1000, 0, 0, "R2");
        // R2: unaligned base, 64 KB
        wr_region(1, 32'h1000_0123, 15, 3, 0, 1, 1, "R2");
        access(32'h1000_0000, 0, 0, "R2");
        access(32'h1000_FFFF, 1, 0, "R2");
        access(32'h1001_0000, 0, 0, "R2");
        access(32'h0FFF_FFFF, 0, 1, "R7");
        // R3: size code below minimum never matches
        wr_region(2, 32'h3000_0000, 5, 3, 1, 1, 1, "R3");
        access(32'h3000_0000, 0, 1, "R3");
        wr_region(2, 32'h3000_0000, 10, 3, 1, 1, 1, "R3");
        access(32'h3000_0004, 0, 1, "R3");

        // R6: every permission code with every priv/write combination
        for (int pm = 0; pm < 4; pm++) begin
            wr_region(3, 32'h2000_0000, 19, pm, 1, 1, 1, "R6");
            for (int pv = 0; pv < 2; pv++) begin
                for (int w = 0; w < 2; w++) begin
                    access(32'h2000_1234, bit'(w), bit'(pv), "R6");
                end
            end
        end

        // R5: higher index overlaps region 3 and wins
        wr_region(4, 32'h2000_0000, 13, 1, 0, 1, 1, "R5");
        access(32'h2000_0010, 0, 0, "R5");
        access(32'h2000_0010, 1, 1, "R5");
        access(32'h2000_4000, 1, 0, "R5");
        // R5: lower index overlapping does not win
        wr_region(2, 32'h2000_0000, 20, 0, 0, 0, 1, "R5");
        access(32'h2000_8000, 1, 0, "R5");
        access(32'h2010_0000, 0, 1, "R5");

        // R4: disabled region never matches
        wr_region(4, 32'h2000_0000, 13, 1, 0, 1, 0, "R4");
        access(32'h2000_0010, 0, 0, "R4");
        wr_region(5, 32'h5000_0000, 12, 3, 1, 1, 0, "R4");
        access(32'h5000_0000, 0, 1, "R4");

        // R1: write and request in the same cycle see old settings
        req_valid = 1; req_addr = 32'h5000_0040; req_write = 0; req_priv = 1;
        wr_region(5, 32'h5000_0000, 12, 3, 1, 0, 1, "R1");
        req_valid = 0;
        access(32'h5000_0040, 0, 1, "R1");

        // R5 / R2: full 4 GB region at top priority covers everything
        wr_region(7, 32'h0000_0000, 31, 2, 0, 1, 1, "R2");
        access(32'hFFFF_FFFF, 0, 0, "R2");
        access(32'h2000_0010, 1, 0, "R5");
        access(32'h8000_0000, 1, 1, "R9");

        // R8: global disable bypasses
        glob_en = 0;
        access(32'h2000_0010, 1, 0, "R8");
        access(32'h0000_0010, 0, 1, "R8");
        glob_en = 1;

        // R10: gaps and back-to-back requests
        cycle("R10");
        cycle("R10");
        req_valid = 1; req_write = 0; req_priv = 1;
        for (int k = 0; k < 6; k++) begin
            req_addr = 32'h0000_0800 + 32'(k * 32'h0100_0000);
            cycle("R10");
        end
        req_valid = 0;
        cycle("R10");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule